// File: doc/BRIEF.md
# CAN Fault Confinement Counter Unit

This block keeps the two error counters of a CAN node, one for transmit-side trouble and one for receive-side trouble, and derives the node's confinement state from them: error-active, error-passive or bus-off. The protocol engine detects bus events and reports each one as a single-cycle pulse. Qualifier inputs accompany some pulses, and a role input says whether the node is acting as transmitter. The unit applies the CAN increment and decrement rules, including their exceptions, and reports the counters, the state, and whether a passive error flag must be sent instead of an active one.

While the node is in bus-off, every event is ignored except the pulse that reports one run of eleven recessive bits. On the 128th such pulse, both counters clear and the node becomes error-active again. Both counters saturate, so neither can wrap.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, `tec` and `rec` are 0, `fc_state` is 0 and `use_passive_flag` is 0.
- R2: `fc_state` encodes 0 = error-active, 1 = error-passive and 2 = bus-off. Outside bus-off the state is 1 when `tec` > 127 or `rec` > 127, and 0 when both are below 128. `use_passive_flag` is 1 exactly when `fc_state` is 1.
- R3: `ev_rx_err` adds 1 to `rec`. If `ev_flag_bit_err` is asserted in the same cycle (a bit error while sending an active error or overload flag), the 1 is not added.
- R4: `ev_rx_dom_after_flag` adds 8 to `rec`.
- R5: `ev_tx_flag` adds 8 to `tec`, except in two cases: `qual_arb_stuff` is asserted with it, or `qual_ack_passive` is asserted with it while the node is error-passive. `qual_ack_passive` has no effect while the node is error-active.
- R6: `ev_flag_bit_err` and `ev_dom_block` each add 8 to `tec` when `node_is_tx` is 1, and 8 to `rec` when `node_is_tx` is 0. The other counter is left unchanged.
- R7: `ev_tx_ok` subtracts 1 from `tec`. A `tec` of 0 stays 0.
- R8: `ev_rx_ok` subtracts 1 from `rec` when `rec` is between 1 and 127. A `rec` of 0 stays 0. A `rec` above 127 becomes exactly 127.
- R9: Increments that arrive in the same cycle add together. `rec` saturates at 255 and `tec` saturates at 256. In any cycle where a counter receives an increment, its decrement event is ignored.
- R10: The node enters bus-off (`fc_state` 2) when `tec` reaches 256. In bus-off, all event inputs other than `ev_idle11` leave both counters unchanged.
- R11: In bus-off, the 128th `ev_idle11` pulse clears both counters and sets `fc_state` to 0. The count restarts at every entry into bus-off. `ev_idle11` has no effect outside bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_is_tx | input | 1 | Node currently acts as transmitter |
| ev_rx_err | input | 1 | Receiver detected an error |
| ev_rx_dom_after_flag | input | 1 | Dominant bit seen as first bit after own error flag |
| ev_tx_flag | input | 1 | Transmitter sent an error flag |
| qual_ack_passive | input | 1 | Qualifier: ACK error with no dominant bit during passive flag |
| qual_arb_stuff | input | 1 | Qualifier: arbitration stuff error on recessive bit read as dominant |
| ev_flag_bit_err | input | 1 | Bit error while sending active error or overload flag |
| ev_dom_block | input | 1 | One more block of eight dominant bits after a flag |
| ev_tx_ok | input | 1 | Successful transmission |
| ev_rx_ok | input | 1 | Successful reception |
| ev_idle11 | input | 1 | One run of eleven recessive bits observed |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| fc_state | output | 2 | Confinement state (0 active, 1 passive, 2 bus-off) |
| use_passive_flag | output | 1 | Send a passive error flag instead of an active one |

## Verification
The receive counter is driven by single events, by stacked events in one cycle, and by long runs of successful receptions. These separate the +1 and +8 paths, show the suppression of the +1 during a flag bit error, and show the clamp to 127 from both 128 and saturated 255. The transmit counter is driven with each qualifier in the error-active state and again in the error-passive state, which tells a state-dependent exception apart from one that applies always. The role input is toggled to show that flag bit errors and dominant blocks reach the correct counter. Bus-off is driven with 127 and then 128 idle pulses to pin the exact recovery boundary, and with other events mixed in to show that they are ignored.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_err_ctr.sv
module fc_err_ctr #(
    parameter int W          = 8,
    parameter int SAT        = 255,
    parameter int INC_W      = 6,
    parameter bit CLAMP_EN   = 1'b0,
    parameter int CLAMP_FROM = 128,
    parameter int CLAMP_VAL  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [INC_W-1:0] inc,
    input  logic             dec,
    output logic [W-1:0]     q
);
    localparam logic [W:0]   SAT_V   = (W+1)'(SAT);
    localparam logic [W-1:0] CFROM_V = W'(CLAMP_FROM);
    localparam logic [W-1:0] CVAL_V  = W'(CLAMP_VAL);

    typedef struct packed {
        logic [W-1:0] val;
    } ctr_s;

    ctr_s cur_q, nxt_d;
    logic [W:0]   sum_d;
    logic [W-1:0] dec_d;

    generate
        if (CLAMP_EN) begin : g_clamp
            always_comb begin
                if (cur_q.val >= CFROM_V)   dec_d = CVAL_V;
                else if (cur_q.val != '0)   dec_d = cur_q.val - 1'b1;
                else                        dec_d = '0;
            end
        end else begin : g_plain
            always_comb begin
                if (cur_q.val != '0) dec_d = cur_q.val - 1'b1;
                else                 dec_d = '0;
            end
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        sum_d = {1'b0, cur_q.val} + {{(W+1-INC_W){1'b0}}, inc};
        if (clr)              nxt_d.val = '0;
        else if (hold)        nxt_d.val = cur_q.val;
        else if (inc != '0)   nxt_d.val = (sum_d > SAT_V) ? SAT_V[W-1:0] : sum_d[W-1:0];
        else if (dec)         nxt_d.val = dec_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign q = cur_q.val;

    // R9
    sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, q} <= SAT_V));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(q));

    // R7
    dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && inc == '0 && !hold && !clr && q == '0) |=> (q == '0));

    generate
        if (CLAMP_EN) begin : g_clamp_chk
            // R8
            clamp_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (dec && inc == '0 && !hold && !clr && q >= CFROM_V) |=> (q == CVAL_V));
        end
    endgenerate
endmodule

// File: rtl/fc_busoff_rec.sv
module fc_busoff_rec #(
    parameter int RUNS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busoff,
    input  logic idle11,
    output logic recovered
);
    localparam int CW = (RUNS > 1) ? $clog2(RUNS) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUNS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rec_s;

    rec_s cur_q, nxt_d;
    logic done_d;

    always_comb begin
        nxt_d  = cur_q;
        done_d = 1'b0;
        if (!busoff) begin
            nxt_d.cnt = '0;
        end else if (idle11) begin
            if (cur_q.cnt == LAST) begin
                done_d    = 1'b1;
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign recovered = done_d;

    // R11
    rec_only_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recovered |-> (busoff && idle11));
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 256,
    parameter int FLAG_INC    = 8,
    parameter int REC_CLAMP   = 127,
    parameter int RECOV_RUNS  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             node_is_tx,
    input  logic             ev_rx_err,
    input  logic             ev_rx_dom_after_flag,
    input  logic             ev_tx_flag,
    input  logic             qual_ack_passive,
    input  logic             qual_arb_stuff,
    input  logic             ev_flag_bit_err,
    input  logic             ev_dom_block,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_ok,
    input  logic             ev_idle11,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic [1:0]       fc_state,
    output logic             use_passive_flag
);
    import can_fc_pkg::*;

    localparam int INC_W = 6;
    localparam logic [INC_W-1:0] INC_BIG  = INC_W'(FLAG_INC);
    localparam logic [INC_W-1:0] INC_ONE  = INC_W'(1);
    localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);

    logic [TEC_W-1:0] tec_q;
    logic [REC_W-1:0] rec_q;
    logic [INC_W-1:0] tec_inc_d, rec_inc_d;
    logic             busoff_d, passive_d, recovered_d, tx_exempt_d;
    fc_state_e        state_d;

    always_comb begin
        busoff_d    = (tec_q >= TEC_OFF);
        passive_d   = !busoff_d && ((tec_q >= TEC_PASS) || (rec_q >= REC_PASS));
        tx_exempt_d = qual_arb_stuff || (qual_ack_passive && passive_d);

        rec_inc_d = '0;
        if (ev_rx_err && !ev_flag_bit_err)      rec_inc_d = rec_inc_d + INC_ONE;
        if (ev_rx_dom_after_flag)               rec_inc_d = rec_inc_d + INC_BIG;
        if (!node_is_tx && ev_flag_bit_err)     rec_inc_d = rec_inc_d + INC_BIG;
        if (!node_is_tx && ev_dom_block)        rec_inc_d = rec_inc_d + INC_BIG;

        tec_inc_d = '0;
        if (ev_tx_flag && !tx_exempt_d)         tec_inc_d = tec_inc_d + INC_BIG;
        if (node_is_tx && ev_flag_bit_err)      tec_inc_d = tec_inc_d + INC_BIG;
        if (node_is_tx && ev_dom_block)         tec_inc_d = tec_inc_d + INC_BIG;

        if (busoff_d)       state_d = FC_BUSOFF;
        else if (passive_d) state_d = FC_PASSIVE;
        else                state_d = FC_ACTIVE;
    end

    fc_err_ctr #(
        .W(TEC_W), .SAT(BUSOFF_LIM), .INC_W(INC_W),
        .CLAMP_EN(1'b0), .CLAMP_FROM(PASSIVE_LIM), .CLAMP_VAL(REC_CLAMP)
    ) u_tec (
        .clk(clk), .rst_n(rst_n), .clr(recovered_d), .hold(busoff_d),
        .inc(tec_inc_d), .dec(ev_tx_ok), .q(tec_q)
    );

    fc_err_ctr #(
        .W(REC_W), .SAT((1 << REC_W) - 1), .INC_W(INC_W),
        .CLAMP_EN(1'b1), .CLAMP_FROM(PASSIVE_LIM), .CLAMP_VAL(REC_CLAMP)
    ) u_rec (
        .clk(clk), .rst_n(rst_n), .clr(recovered_d), .hold(busoff_d),
        .inc(rec_inc_d), .dec(ev_rx_ok), .q(rec_q)
    );

    fc_busoff_rec #(.RUNS(RECOV_RUNS)) u_recov (
        .clk(clk), .rst_n(rst_n), .busoff(busoff_d),
        .idle11(ev_idle11), .recovered(recovered_d)
    );

    assign tec              = tec_q;
    assign rec              = rec_q;
    assign fc_state         = state_d;
    assign use_passive_flag = (state_d == FC_PASSIVE);

    // R11
    recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recovered_d |=> (tec == '0 && rec == '0 && fc_state == 2'd0));

    // R10
    busoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_state == 2'd2 && !ev_idle11) |=> (fc_state == 2'd2));

    // R5
    arb_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_flag && qual_arb_stuff && !ev_flag_bit_err && !ev_dom_block
         && !ev_tx_ok && fc_state != 2'd2) |=> $stable(tec));

    // R2
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({use_passive_flag, fc_state == 2'd2}) && fc_state != 2'd3);
endmodule

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic node_is_tx = 1'b0;
    logic ev_rx_err = 0, ev_rx_dom_after_flag = 0, ev_tx_flag = 0;
    logic qual_ack_passive = 0, qual_arb_stuff = 0, ev_flag_bit_err = 0;
    logic ev_dom_block = 0, ev_tx_ok = 0, ev_rx_ok = 0, ev_idle11 = 0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] fc_state;
    logic use_passive_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam int M_RXERR = 1, M_RXDOM = 2, M_TXFLAG = 4, M_ACK = 8, M_ARB = 16;
    localparam int M_FBE = 32, M_DOMB = 64, M_TXOK = 128, M_RXOK = 256, M_IDLE = 512;

    always #(CLK_P/2) clk = ~clk;

    can_fault_conf u_dut (
        .clk(clk), .rst_n(rst_n), .node_is_tx(node_is_tx),
        .ev_rx_err(ev_rx_err), .ev_rx_dom_after_flag(ev_rx_dom_after_flag),
        .ev_tx_flag(ev_tx_flag), .qual_ack_passive(qual_ack_passive),
        .qual_arb_stuff(qual_arb_stuff), .ev_flag_bit_err(ev_flag_bit_err),
        .ev_dom_block(ev_dom_block), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_idle11(ev_idle11), .tec(tec), .rec(rec), .fc_state(fc_state),
        .use_passive_flag(use_passive_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int m, input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_rx_err            = m[0];
            ev_rx_dom_after_flag = m[1];
            ev_tx_flag           = m[2];
            qual_ack_passive     = m[3];
            qual_arb_stuff       = m[4];
            ev_flag_bit_err      = m[5];
            ev_dom_block         = m[6];
            ev_tx_ok             = m[7];
            ev_rx_ok             = m[8];
            ev_idle11            = m[9];
            @(negedge clk);
            {ev_rx_err, ev_rx_dom_after_flag, ev_tx_flag, qual_ack_passive, qual_arb_stuff,
             ev_flag_bit_err, ev_dom_block, ev_tx_ok, ev_rx_ok, ev_idle11} = '0;
        end
    endtask

    task automatic t_reset();
        chk("R1", "tec", tec, 0);
        chk("R1", "rec", rec, 0);
        chk("R1", "state", fc_state, 0);
        chk("R1", "passive flag", use_passive_flag, 0);
    endtask

    task automatic t_rx_events();
        node_is_tx = 1'b0;
        pulse(M_RXERR, 3);
        chk("R3", "rec after 3 rx errors", rec, 3);
        pulse(M_RXERR | M_FBE);
        chk("R3", "rec rx error during flag bit error", rec, 11);
        chk("R6", "tec unchanged as receiver", tec, 0);
        pulse(M_RXDOM);
        chk("R4", "rec after dominant after flag", rec, 19);
        pulse(M_RXOK);
        chk("R8", "rec decrement", rec, 18);
        pulse(M_DOMB);
        chk("R6", "rec dom block receiver", rec, 26);
        pulse(M_RXOK, 30);
        chk("R8", "rec floor at zero", rec, 0);
        pulse(M_RXERR | M_RXOK);
        chk("R9", "rec inc wins over dec", rec, 1);
        pulse(M_RXOK);
    endtask

    task automatic t_rx_passive();
        pulse(M_RXDOM, 16);
        chk("R2", "rec 128 state", fc_state, 1);
        chk("R2", "rec 128 passive flag", use_passive_flag, 1);
        pulse(M_RXOK);
        chk("R8", "rec clamp from 128", rec, 127);
        chk("R2", "back to active", fc_state, 0);
        pulse(M_RXDOM, 17);
        chk("R9", "rec saturates", rec, 255);
        pulse(M_RXOK);
        chk("R8", "rec clamp from 255", rec, 127);
        pulse(M_RXOK, 128);
        chk("R8", "rec back to zero", rec, 0);
    endtask

    task automatic t_tx_events();
        pulse(M_TXFLAG);
        chk("R5", "tec after flag", tec, 8);
        pulse(M_TXFLAG | M_ARB);
        chk("R5", "arb stuff exempt", tec, 8);
        pulse(M_TXFLAG | M_ACK);
        chk("R5", "ack qualifier ignored when active", tec, 16);
        pulse(M_TXOK);
        chk("R7", "tec decrement", tec, 15);
        pulse(M_TXOK, 20);
        chk("R7", "tec floor at zero", tec, 0);
        node_is_tx = 1'b1;
        pulse(M_FBE);
        chk("R6", "tec flag bit error transmitter", tec, 8);
        chk("R6", "rec unchanged as transmitter", rec, 0);
        pulse(M_DOMB);
        chk("R6", "tec dom block transmitter", tec, 16);
        pulse(M_TXFLAG, 15);
        chk("R2", "tec 136 state", fc_state, 1);
        pulse(M_TXFLAG | M_ACK);
        chk("R5", "ack exempt when passive", tec, 136);
        pulse(M_TXFLAG | M_TXOK);
        chk("R9", "tec inc wins over dec", tec, 144);
    endtask

    task automatic t_busoff();
        pulse(M_RXERR, 5);
        chk("R3", "rec before bus-off", rec, 5);
        pulse(M_TXFLAG, 14);
        chk("R10", "tec at bus-off", tec, 256);
        chk("R10", "bus-off state", fc_state, 2);
        chk("R2", "no passive flag in bus-off", use_passive_flag, 0);
        pulse(M_TXFLAG | M_DOMB | M_FBE);
        chk("R9", "tec saturated", tec, 256);
        pulse(M_RXERR | M_RXDOM);
        chk("R10", "rec frozen in bus-off", rec, 5);
        pulse(M_TXOK | M_RXOK);
        chk("R10", "tec frozen on tx ok", tec, 256);
        chk("R10", "rec frozen on rx ok", rec, 5);
        pulse(M_IDLE, 127);
        chk("R11", "still bus-off after 127", fc_state, 2);
        pulse(M_IDLE);
        chk("R11", "tec cleared", tec, 0);
        chk("R11", "rec cleared", rec, 0);
        chk("R11", "active after recovery", fc_state, 0);
        pulse(M_IDLE);
        chk("R11", "idle outside bus-off state", fc_state, 0);
        chk("R11", "idle outside bus-off tec", tec, 0);
    endtask

    task automatic t_recount();
        node_is_tx = 1'b1;
        pulse(M_DOMB, 32);
        chk("R10", "second bus-off", fc_state, 2);
        pulse(M_IDLE, 127);
        chk("R11", "count restarted", fc_state, 2);
        pulse(M_IDLE);
        chk("R11", "second recovery", fc_state, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all requirements actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_events();
        t_rx_passive();
        t_tx_events();
        t_busoff();
        t_recount();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule